// File: doc/BRIEF.md
# Voltage and Frequency Transition Sequencer

This block moves a clocked subsystem between operating points as its workload demand changes. The workload level comes in as an unsigned number. Each frequency index has a capacity of `(index+1)*CAP_STEP`. The block picks the smallest frequency index whose capacity covers the demand, and then the smallest supply index able to carry that frequency. It drives a supply-select code to a regulator and a clock-select code to a clock generator. After each change it waits for the matching handshake before it takes the next step.

The order of the two steps follows the direction of the move. When speeding up, the supply is raised first and the clock follows once the supply is settled. When slowing down, the clock drops first and the supply is lowered only after the clock has locked. A demand change that arrives while a move is in progress is held, and it is acted on when the move ends. A missing handshake within a programmable window raises a fault and puts the operating point back to the last acknowledged one.

Top module: `dvfs_seq`

## Requirements
- R1: A move starts only when the required frequency index changes. A workload change that maps to the same index causes no busy cycle and no output change.
- R2: The target frequency index is the smallest `f` with `(f+1)*CAP_STEP >= workload`, clamped to `NF-1`. With the defaults, a workload of 100 gives index 3 and 200 gives index 6.
- R3: The target supply index is `f / F_PER_V` (with the defaults, `f/2`). Whenever the block is idle, `freq_sel_o / F_PER_V <= volt_sel_o`.
- R4: On an upward move that needs more supply, `volt_sel_o` changes first. `freq_sel_o` holds until a cycle with `v_settled_i` high, and it takes the new value at that clock edge.
- R5: On a downward move, `freq_sel_o` changes first. `volt_sel_o` holds until `clk_locked_i` is seen, and only then is it lowered.
- R6: If the current supply already supports the new frequency on an upward move, only the clock is changed. The move waits only for `clk_locked_i`.
- R7: Demand changes seen during a move are latched, and only the latest one is acted on after the move completes.
- R8: `busy_o` is high in every cycle of a move. `done_o` is a one-cycle pulse in the first idle cycle after the last handshake, and it never coincides with `busy_o`.
- R9: If a wait lasts `timeout_i+1` cycles without its handshake, the block raises `fault_o`, reverts the output changed in that step to its last acknowledged value, and returns to idle without retrying. `fault_o` stays high until the next successful `done_o`.
- R10: After reset both select codes are 0, and `busy_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| workload_i | input | WL_W | Demanded workload level |
| timeout_i | input | TO_W | Handshake wait limit, in cycles minus one |
| v_settled_i | input | 1 | Regulator reports the supply has settled |
| clk_locked_i | input | 1 | Clock generator reports lock |
| volt_sel_o | output | VW | Supply index to the regulator |
| freq_sel_o | output | FW | Frequency index to the clock generator |
| busy_o | output | 1 | A move is in progress |
| done_o | output | 1 | One-cycle pulse when the new point is valid |
| fault_o | output | 1 | A handshake timed out |

## Verification
Two events can land on the same clock edge. One is a new demand change being latched. The other is a move completing, or the idle state picking up the pending request. The bench provokes this by changing the workload twice while a move is busy, with some changes placed near the completing handshake. It judges the outcome against a behavioural model, which requires that the last demand wins and that no stale target is executed. The bench also holds back a handshake so that the timeout coincides with a pending step. It then checks that only the unacknowledged output reverts.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_VUP  = 3'd1,
      ST_FUP  = 3'd2,
      ST_FDN  = 3'd3,
      ST_VDN  = 3'd4
   } dvfs_st_e;
endpackage

// File: rtl/dvfs_freq_map.sv
module dvfs_freq_map #(
   parameter int WL_W     = 8,
   parameter int NF       = 8,
   parameter int CAP_STEP = 32,
   parameter int FW       = 3
) (
   input  logic [WL_W-1:0] workload,
   output logic [FW-1:0]   f_idx
);
   // lowest index whose capacity covers the demand; scan downward so the smallest wins
   always_comb begin
      f_idx = FW'(NF-1);
      for (int i = NF-1; i >= 0; i--) begin
         if ((i+1)*CAP_STEP >= int'(workload)) f_idx = FW'(i);
      end
   end
endmodule

// File: rtl/dvfs_volt_map.sv
module dvfs_volt_map #(
   parameter int F_PER_V = 2,
   parameter int FW      = 3,
   parameter int VW      = 2
) (
   input  logic [FW-1:0] f_idx,
   output logic [VW-1:0] v_idx
);
   localparam int SH   = (F_PER_V > 1) ? $clog2(F_PER_V) : 0;
   localparam bit POW2 = ((1 << SH) == F_PER_V);

   generate
      if (POW2) begin : g_shift
         logic [FW-1:0] sh_v;
         assign sh_v  = f_idx >> SH;
         assign v_idx = VW'(sh_v);
      end else begin : g_div
         int q;
         assign q     = int'(f_idx) / F_PER_V;
         assign v_idx = VW'(q);
      end
   endgenerate
endmodule

// File: rtl/dvfs_change_latch.sv
module dvfs_change_latch #(
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] req_f,
   input  logic          take,
   output logic          pend,
   output logic [FW-1:0] pend_f
);
   logic [FW-1:0] prev_q;
   logic          chg;

   assign chg = (req_f != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend   <= 1'b0;
         pend_f <= '0;
      end else begin
         prev_q <= req_f;
         if (chg) begin
            pend   <= 1'b1;
            pend_f <= req_f;
         end else if (take) begin
            pend   <= 1'b0;
         end
      end
   end

   // R7: a detected change is always held for the sequencer
   a_r7_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (pend && pend_f == $past(req_f)));
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            run,
   input  logic [TO_W-1:0] limit,
   output logic            expired
);
   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr)                     cnt_q <= '0;
      else if (run && cnt_q != limit)   cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == limit);

   // R9: the wait window restarts at every step
   a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
   import dvfs_seq_pkg::*;
#(
   parameter int WL_W     = 8,
   parameter int NF       = 8,
   parameter int CAP_STEP = 32,
   parameter int F_PER_V  = 2,
   parameter int TO_W     = 8,
   localparam int FW      = (NF > 1) ? $clog2(NF) : 1,
   localparam int NV      = (NF + F_PER_V - 1) / F_PER_V,
   localparam int VW      = (NV > 1) ? $clog2(NV) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WL_W-1:0] workload_i,
   input  logic [TO_W-1:0] timeout_i,
   input  logic            v_settled_i,
   input  logic            clk_locked_i,
   output logic [VW-1:0]   volt_sel_o,
   output logic [FW-1:0]   freq_sel_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            fault_o
);
   generate
      if (NF < 2)       begin : g_bad_nf  $error("dvfs_seq: NF must be at least 2"); end
      if (F_PER_V < 1)  begin : g_bad_fpv $error("dvfs_seq: F_PER_V must be positive"); end
      if (CAP_STEP < 1) begin : g_bad_cap $error("dvfs_seq: CAP_STEP must be positive"); end
      if (TO_W < 1)     begin : g_bad_to  $error("dvfs_seq: TO_W must be positive"); end
   endgenerate

   dvfs_st_e      st_q, st_d;
   logic [FW-1:0] f_q, f_d, sf_q, sf_d, tf_q, tf_d;
   logic [VW-1:0] v_q, v_d, sv_q, sv_d, tv_q, tv_d;
   logic          done_d, fault_d, take;
   logic [FW-1:0] req_f, pend_f;
   logic [VW-1:0] pend_v;
   logic          pend, expired, t_clr;

   dvfs_freq_map #(.WL_W(WL_W), .NF(NF), .CAP_STEP(CAP_STEP), .FW(FW)) u_fmap (
      .workload(workload_i), .f_idx(req_f));

   dvfs_change_latch #(.FW(FW)) u_latch (
      .clk(clk), .rst_n(rst_n), .req_f(req_f), .take(take),
      .pend(pend), .pend_f(pend_f));

   dvfs_volt_map #(.F_PER_V(F_PER_V), .FW(FW), .VW(VW)) u_vmap (
      .f_idx(pend_f), .v_idx(pend_v));

   assign t_clr = (st_d != st_q);

   dvfs_wait_timer #(.TO_W(TO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .run(st_q != ST_IDLE),
      .limit(timeout_i), .expired(expired));

   always_comb begin
      st_d    = st_q;
      f_d     = f_q;
      v_d     = v_q;
      sf_d    = sf_q;
      sv_d    = sv_q;
      tf_d    = tf_q;
      tv_d    = tv_q;
      done_d  = 1'b0;
      fault_d = fault_o;
      take    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (pend) begin
               take = 1'b1;
               tf_d = pend_f;
               tv_d = pend_v;
               if (pend_f > f_q) begin
                  if (pend_v > v_q) begin
                     v_d  = pend_v;
                     st_d = ST_VUP;
                  end else begin
                     f_d  = pend_f;
                     st_d = ST_FUP;
                  end
               end else if (pend_f < f_q) begin
                  f_d  = pend_f;
                  st_d = ST_FDN;
               end
            end
         end
         ST_VUP: begin
            if (v_settled_i) begin
               sv_d = v_q;
               f_d  = tf_q;
               st_d = ST_FUP;
            end else if (expired) begin
               v_d = sv_q; fault_d = 1'b1; st_d = ST_IDLE;
            end
         end
         ST_FUP: begin
            if (clk_locked_i) begin
               sf_d = f_q; done_d = 1'b1; fault_d = 1'b0; st_d = ST_IDLE;
            end else if (expired) begin
               f_d = sf_q; fault_d = 1'b1; st_d = ST_IDLE;
            end
         end
         ST_FDN: begin
            if (clk_locked_i) begin
               sf_d = f_q;
               if (tv_q < v_q) begin
                  v_d  = tv_q;
                  st_d = ST_VDN;
               end else begin
                  done_d = 1'b1; fault_d = 1'b0; st_d = ST_IDLE;
               end
            end else if (expired) begin
               f_d = sf_q; fault_d = 1'b1; st_d = ST_IDLE;
            end
         end
         ST_VDN: begin
            if (v_settled_i) begin
               sv_d = v_q; done_d = 1'b1; fault_d = 1'b0; st_d = ST_IDLE;
            end else if (expired) begin
               v_d = sv_q; fault_d = 1'b1; st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         f_q     <= '0;
         v_q     <= '0;
         sf_q    <= '0;
         sv_q    <= '0;
         tf_q    <= '0;
         tv_q    <= '0;
         done_o  <= 1'b0;
         fault_o <= 1'b0;
      end else begin
         st_q    <= st_d;
         f_q     <= f_d;
         v_q     <= v_d;
         sf_q    <= sf_d;
         sv_q    <= sv_d;
         tf_q    <= tf_d;
         tv_q    <= tv_d;
         done_o  <= done_d;
         fault_o <= fault_d;
      end
   end

   assign freq_sel_o = f_q;
   assign volt_sel_o = v_q;
   assign busy_o     = (st_q != ST_IDLE);

   // R4: clock holds while the raised supply is still settling
   a_r4_freq_waits_supply: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_VUP && !v_settled_i) |=> $stable(freq_sel_o));
   // R5: supply holds while the lowered clock is still locking
   a_r5_volt_waits_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FDN && !clk_locked_i) |=> $stable(volt_sel_o));
   // R3: an idle operating point is always supported by its supply
   a_r3_idle_point_safe: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (int'(freq_sel_o) / F_PER_V <= int'(volt_sel_o)));
   // R8: completion pulse is single and outside the busy window
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9: a fault always lands the block in idle
   a_r9_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> !busy_o);
endmodule

// File: tb/dvfs_seq_tb_top.sv
module dvfs_seq_tb_top;
   localparam int NF = 8;
   localparam int CAP = 32;
   localparam int FPV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] workload_i = '0;
   logic [7:0] timeout_i = 8'd20;
   logic       v_settled_i = 1'b0;
   logic       clk_locked_i = 1'b0;
   logic [1:0] volt_sel_o;
   logic [2:0] freq_sel_o;
   logic       busy_o, done_o, fault_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dvfs_seq dut_i (
      .clk(clk), .rst_n(rst_n), .workload_i(workload_i), .timeout_i(timeout_i),
      .v_settled_i(v_settled_i), .clk_locked_i(clk_locked_i),
      .volt_sel_o(volt_sel_o), .freq_sel_o(freq_sel_o),
      .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o));

   // ---------------- regulator / clock generator responders
   bit block_v = 0, block_f = 0;
   int vdelay = 3, fdelay = 4;
   int vcnt = 0, fcnt = 0;
   int last_v = 0, last_f = 0;
   always @(negedge clk) begin
      v_settled_i <= 1'b0;
      clk_locked_i <= 1'b0;
      if (int'(volt_sel_o) != last_v) begin
         last_v = int'(volt_sel_o); vcnt = vdelay;
      end else if (vcnt > 0) begin
         vcnt--;
         if (vcnt == 0 && !block_v) v_settled_i <= 1'b1;
      end
      if (int'(freq_sel_o) != last_f) begin
         last_f = int'(freq_sel_o); fcnt = fdelay;
      end else if (fcnt > 0) begin
         fcnt--;
         if (fcnt == 0 && !block_f) clk_locked_i <= 1'b1;
      end
   end

   // ---------------- behavioural reference model
   int m_st, m_f, m_v, s_f, s_v, t_f, t_v, m_prev, m_pf, m_cnt;
   bit m_pend, m_done, m_fault;

   function automatic int need_f(int w);
      for (int i = 0; i < NF; i++) if ((i+1)*CAP >= w) return i;
      return NF-1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_f = 0; m_v = 0; s_f = 0; s_v = 0; t_f = 0; t_v = 0;
         m_prev = 0; m_pf = 0; m_cnt = 0; m_pend = 0; m_done = 0; m_fault = 0;
      end else begin
         int rq, ost, to;
         bit took, vs, lk;
         rq = need_f(int'(workload_i));
         to = int'(timeout_i);
         vs = v_settled_i; lk = clk_locked_i;
         took = 0; ost = m_st; m_done = 0;
         if (m_st == 0) begin
            if (m_pend) begin
               took = 1; t_f = m_pf; t_v = m_pf / FPV;
               if (t_f > m_f) begin
                  if (t_v > m_v) begin m_v = t_v; m_st = 1; end
                  else begin m_f = t_f; m_st = 2; end
               end else if (t_f < m_f) begin
                  m_f = t_f; m_st = 3;
               end
            end
         end else begin
            bit ack;
            ack = (m_st == 1 || m_st == 4) ? vs : lk;
            if (ack) begin
               if (m_st == 1) begin s_v = m_v; m_f = t_f; m_st = 2; end
               else if (m_st == 2) begin s_f = m_f; m_done = 1; m_fault = 0; m_st = 0; end
               else if (m_st == 3) begin
                  s_f = m_f;
                  if (t_v < m_v) begin m_v = t_v; m_st = 4; end
                  else begin m_done = 1; m_fault = 0; m_st = 0; end
               end else begin s_v = m_v; m_done = 1; m_fault = 0; m_st = 0; end
            end else if (m_cnt == to) begin
               if (m_st == 1 || m_st == 4) m_v = s_v; else m_f = s_f;
               m_fault = 1; m_st = 0;
            end
         end
         if (m_st != ost) m_cnt = 0;
         else if (m_st != 0 && m_cnt != to) m_cnt++;
         if (rq != m_prev) begin m_pend = 1; m_pf = rq; end
         else if (took) m_pend = 0;
         m_prev = rq;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk(int'(freq_sel_o) == m_f, "R4 R5 freq_sel", int'(freq_sel_o), m_f);
         chk(int'(volt_sel_o) == m_v, "R4 R5 volt_sel", int'(volt_sel_o), m_v);
         chk(busy_o == (m_st != 0), "R8 busy", int'(busy_o), int'(m_st != 0));
         chk(done_o == m_done, "R8 done", int'(done_o), int'(m_done));
         chk(fault_o == m_fault, "R9 fault", int'(fault_o), int'(m_fault));
      end
      if (cyc > 100000 && !finished) begin
         finished = 1;
         chk(0, "watchdog", cyc, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   int busy_seen, done_seen;
   always @(negedge clk) begin
      if (busy_o) busy_seen++;
      if (done_o) done_seen++;
   end

   task automatic settle();
      repeat (3) @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(freq_sel_o == 0 && volt_sel_o == 0, "R10 selects after reset",
          int'({volt_sel_o, freq_sel_o}), 0);
      chk(!busy_o && !done_o && !fault_o, "R10 flags after reset",
          int'({busy_o, done_o, fault_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: same index, no activity
      busy_seen = 0;
      workload_i = 8'd10;
      repeat (8) @(negedge clk);
      chk(busy_seen == 0, "R1 no move for same index", busy_seen, 0);

      // R2 R3 R4: upward with supply first
      done_seen = 0;
      workload_i = 8'd100;
      settle();
      chk(int'(freq_sel_o) == 3, "R2 freq for 100", int'(freq_sel_o), 3);
      chk(int'(volt_sel_o) == 1, "R3 volt for f3", int'(volt_sel_o), 1);
      chk(done_seen == 1, "R8 one done pulse", done_seen, 1);

      // R5: downward, clock first
      workload_i = 8'd40;
      settle();
      chk(int'(freq_sel_o) == 1 && int'(volt_sel_o) == 0, "R5 down to f1 v0",
          int'({volt_sel_o, freq_sel_o}), 1);

      // R1 again
      busy_seen = 0;
      workload_i = 8'd60;
      repeat (8) @(negedge clk);
      chk(busy_seen == 0, "R1 same index 60", busy_seen, 0);

      // R6: f2 then f3 share a supply index
      workload_i = 8'd80;
      settle();
      workload_i = 8'd120;
      settle();
      chk(int'(freq_sel_o) == 3 && int'(volt_sel_o) == 1, "R6 clock-only step",
          int'({volt_sel_o, freq_sel_o}), 11);

      // R7: changes during a move, last one wins
      workload_i = 8'd150;
      repeat (4) @(negedge clk);
      workload_i = 8'd30;
      repeat (2) @(negedge clk);
      workload_i = 8'd210;
      settle();
      settle();
      chk(int'(freq_sel_o) == 6 && int'(volt_sel_o) == 3, "R7 final point",
          int'({volt_sel_o, freq_sel_o}), 30);

      // R9: supply never settles
      workload_i = 8'd100;
      settle();
      block_v = 1; timeout_i = 8'd5;
      workload_i = 8'd255;
      settle();
      chk(fault_o == 1'b1, "R9 fault raised", int'(fault_o), 1);
      chk(int'(volt_sel_o) == 1 && int'(freq_sel_o) == 3, "R9 reverted point",
          int'({volt_sel_o, freq_sel_o}), 11);
      busy_seen = 0;
      repeat (10) @(negedge clk);
      chk(busy_seen == 0, "R9 no retry", busy_seen, 0);

      block_v = 0;
      workload_i = 8'd200;
      settle();
      chk(fault_o == 1'b0, "R9 fault cleared by done", int'(fault_o), 0);

      // R9: clock never locks on the way down
      block_f = 1;
      workload_i = 8'd0;
      settle();
      chk(fault_o && int'(freq_sel_o) == 6, "R9 clock reverted", int'(freq_sel_o), 6);
      block_f = 0;
      repeat (5) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule